// File: doc/BRIEF.md
# Peripheral Interrupt Mask Aggregator

This block collects level or pulse interrupt requests from a set of peripherals and folds them onto a smaller number of general-purpose event lines headed for a core event controller. Each source passes through its own enable bit; the enabled sources that share an event line are ORed together. Source `s` always lands on event `s mod N_EVT`.

Every event line goes through a two-flop synchronizer and a rising-edge detector. Each detected edge sets a per-event request latch that the core sees. The core clears that latch by raising its pending-acknowledge bit for the event. An edge that arrives while the acknowledge is held high sets the latch again, so one more occurrence waits in the queue while the first is being serviced. A small register port gives access to the enable mask, a live view of the raw requests, and a per-source wakeup enable. A registered wakeup output tells an idle core that an enabled request is present.

Top module: `irq_event_agg`

## Requirements
- R1: After reset the enable mask and the wakeup-enable register read 0, all event request outputs are 0 and the wakeup output is 0.
- R2: Register address 0 holds the enable mask, which is read/write. A bit at 1 lets that source reach its event line. A bit at 0 blocks it, so a rising request on that source never sets a latch.
- R3: Register address 1 reads the raw source requests bit for bit, with or without the mask. Writes to address 1 change nothing.
- R4: Register address 2 holds the per-source wakeup enable, which is read/write.
- R5: Source s drives event s mod N_EVT. An event line is high when any enabled source mapped to it is high.
- R6: When an event line rises because a source changes between two clock edges, its request output goes high on the third rising clock edge after that change.
- R7: A rising edge on an event's pending-acknowledge input clears that event's request output at that clock edge, unless a new event edge is detected at the same edge.
- R8: A new rising edge on an event line while its acknowledge stays high sets the request output again. It stays set until the acknowledge next rises.
- R9: While an event line stays high, for example when a second source on the same event rises while the first is still high, no further edge is produced and a cleared request stays cleared.
- R10: The wakeup output is registered. At each clock edge it takes the value of core_idle AND the OR over sources of (request AND wakeup enable). The mask does not affect it.
- R11: Register address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | N_SRC | Peripheral request levels |
| core_idle | input | 1 | Core is idle or asleep |
| evt_ack | input | N_EVT | Per-event pending acknowledge from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mask, 1 status, 2 wakeup enable, 3 none) |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Register read data for reg_addr (combinational) |
| evt_req | output | N_EVT | Per-event latched request toward the core |
| wake_o | output | 1 | Wakeup request for an idle core |

## Verification
The bench targets exact edge-to-request latency. A design that skips a synchronizer stage raises the request a cycle early, and one with an extra stage raises it a cycle late. It holds the acknowledge high across a fresh edge. A design that clears on the acknowledge level instead of its rise drops the queued request. It raises a second source on an already-high event line, which catches designs that detect edges per source instead of per event. It also checks masked sources, writes to the status address, and wakeup with a zero mask. These catch mask logic placed on the wrong path.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    RA_MASK = 2'd0,
    RA_STAT = 2'd1,
    RA_WAKE = 2'd2,
    RA_NONE = 2'd3
  } reg_sel_e;

  // static source-to-event routing
  function automatic int evt_of_src(input int s, input int n_evt);
    return s % n_evt;
  endfunction
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [N_SRC-1:0] wdata,
  input  logic [N_SRC-1:0] src_lvl,
  output logic [N_SRC-1:0] rdata,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] wken_q
);
  logic             mask_en, wken_en;
  logic [N_SRC-1:0] mask_d, wken_d;

  always_comb begin
    mask_en = wr_en && (addr == RA_MASK);
    wken_en = wr_en && (addr == RA_WAKE);
    mask_d  = wdata;
    wken_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      wken_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (wken_en) wken_q <= wken_d;
    end
  end

  always_comb begin
    unique case (addr)
      RA_MASK: rdata = mask_q;
      RA_STAT: rdata = src_lvl;
      RA_WAKE: rdata = wken_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_map.sv
module irq_agg_map
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int N_EVT = 4
) (
  input  logic [N_SRC-1:0] src_lvl,
  input  logic [N_SRC-1:0] mask_q,
  output logic [N_EVT-1:0] evt_lvl
);
  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    always_comb begin
      evt_lvl[e] = 1'b0;
      for (int s = 0; s < N_SRC; s++) begin
        if (evt_of_src(s, N_EVT) == e)
          evt_lvl[e] = evt_lvl[e] | (src_lvl[s] & mask_q[s]);
      end
    end
  end
endmodule

// File: rtl/irq_agg_evt.sv
module irq_agg_evt #(
  parameter int N_EVT    = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_lvl,
  input  logic [N_EVT-1:0] ack,
  output logic [N_EVT-1:0] req_q,
  output logic [N_EVT-1:0] edge_o,
  output logic [N_EVT-1:0] ack_rise_o
);
  localparam int LAST = SYNC_LEN - 1;

  logic [N_EVT-1:0] sync_q [SYNC_LEN];
  logic [N_EVT-1:0] prev_q, ack_q, req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= evt_lvl;
  end

  for (genvar i = 1; i < SYNC_LEN; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= '0;
      else        sync_q[i] <= sync_q[i-1];
    end
  end

  always_comb begin
    edge_o     = sync_q[LAST] & ~prev_q;
    ack_rise_o = ack & ~ack_q;
    req_d      = edge_o | (req_q & ~ack_rise_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ack_q  <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= sync_q[LAST];
      ack_q  <= ack;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg #(
  parameter int N_SRC = 8,
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic             core_idle,
  input  logic [N_EVT-1:0] evt_ack,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic [N_EVT-1:0] evt_req,
  output logic             wake_o
);
  logic             rs0_q, rst_int_n;
  logic [N_SRC-1:0] mask_q, wken_q;
  logic [N_EVT-1:0] evt_lvl, evt_edge, ack_rise;
  logic             wake_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q     <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rs0_q     <= 1'b1;
      rst_int_n <= rs0_q;
    end
  end

  irq_agg_regs #(.N_SRC(N_SRC)) regs_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .src_lvl(src_req),
    .rdata  (reg_rdata),
    .mask_q (mask_q),
    .wken_q (wken_q)
  );

  irq_agg_map #(.N_SRC(N_SRC), .N_EVT(N_EVT)) map_i (
    .src_lvl(src_req),
    .mask_q (mask_q),
    .evt_lvl(evt_lvl)
  );

  irq_agg_evt #(.N_EVT(N_EVT)) evt_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt_lvl   (evt_lvl),
    .ack       (evt_ack),
    .req_q     (evt_req),
    .edge_o    (evt_edge),
    .ack_rise_o(ack_rise)
  );

  always_comb wake_d = core_idle & (|(src_req & wken_q));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) wake_o <= 1'b0;
    else            wake_o <= wake_d;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int N_SRC = 8,
  parameter int N_EVT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_idle,
  input logic             wake_o,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_EVT-1:0] evt_edge,
  input logic [N_EVT-1:0] ack_rise,
  input logic [N_EVT-1:0] evt_req
);
  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_edge) & ~evt_req) == '0));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ack_rise) & ~$past(evt_edge) & evt_req) == '0));

  assert_set_only_by_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_req & ~$past(evt_req) & ~$past(evt_edge)) == '0));

  assert_masked_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q, 3) == '0 && $past(mask_q, 2) == '0 && $past(mask_q) == '0)
      |-> (evt_edge == '0));

  assert_wake_needs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_idle |=> !wake_o);
endmodule

bind irq_event_agg irq_agg_chk #(.N_SRC(N_SRC), .N_EVT(N_EVT)) chk_i (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .core_idle(core_idle),
  .wake_o   (wake_o),
  .mask_q   (mask_q),
  .evt_edge (evt_edge),
  .ack_rise (ack_rise),
  .evt_req  (evt_req)
);

// File: tb/irq_event_agg_tb_top.sv
`timescale 1ns/1ps
module irq_event_agg_tb_top;
  localparam int NS = 8;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_req;
  logic          core_idle;
  logic [NE-1:0] evt_ack;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [NS-1:0] reg_wdata;
  logic [NS-1:0] reg_rdata;
  logic [NE-1:0] evt_req;
  logic          wake_o;

  always #2.5 clk = ~clk;

  irq_event_agg #(.N_SRC(NS), .N_EVT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .core_idle(core_idle),
    .evt_ack(evt_ack), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_req(evt_req),
    .wake_o(wake_o)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // behavioural reference model
  logic [NS-1:0] m_mask, m_wen;
  logic [NE-1:0] m_req, m_aprev;
  logic [NE-1:0] m_hist [$];
  logic          m_wake;

  always @(posedge clk) begin : mdl
    logic [NE-1:0] lvl, edg, arise;
    if (!rst_n) begin
      m_mask = '0; m_wen = '0; m_req = '0; m_aprev = '0; m_wake = 1'b0;
      m_hist = {};
      repeat (4) m_hist.push_front('0);
    end else begin
      lvl = '0;
      for (int s = 0; s < NS; s++)
        if (src_req[s] && m_mask[s]) lvl[s % NE] = 1'b1;
      edg     = m_hist[1] & ~m_hist[2];
      arise   = evt_ack & ~m_aprev;
      m_aprev = evt_ack;
      m_req   = edg | (m_req & ~arise);
      m_wake  = core_idle & (|(src_req & m_wen));
      m_hist.push_front(lvl);
      if (m_hist.size() > 4) void'(m_hist.pop_back());
      if (reg_wr) begin
        if (reg_addr == 2'd0) m_mask = reg_wdata;
        if (reg_addr == 2'd2) m_wen  = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R5 model evt_req", 32'(evt_req), 32'(m_req));
      chk("R10 model wake_o", 32'(wake_o), 32'(m_wake));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [NS-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    done = 1'b1;
    report();
  end

  initial begin
    logic [NS-1:0] d;
    rst_n = 1'b0; src_req = '0; core_idle = 1'b0; evt_ack = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();
    cmp_on = 1'b1;

    // R1 reset state
    chk("R1 evt_req", 32'(evt_req), 0);
    chk("R1 wake_o", 32'(wake_o), 0);
    rd(2'd0, d); chk("R1 mask", 32'(d), 0);
    rd(2'd2, d); chk("R1 wake enable", 32'(d), 0);

    // R2 mask readback, R11 empty address
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2 mask readback", 32'(d), 32'hFF);
    rd(2'd3, d); chk("R11 addr3", 32'(d), 0);

    // R6 latency on source 0 -> event 0
    src_req = 8'h01;
    tick(); tick();
    chk("R6 not yet", 32'(evt_req[0]), 0);
    tick();
    chk("R6 set on third edge", 32'(evt_req[0]), 1);
    rd(2'd1, d); chk("R3 status", 32'(d), 32'h01);

    // R3 status write ignored
    wr(2'd1, 8'hAA);
    rd(2'd1, d); chk("R3 status write ignored", 32'(d), 32'h01);

    // R9 second source on same event, R7 clear
    src_req = 8'h11;
    repeat (4) tick();
    chk("R9 still set", 32'(evt_req[0]), 1);
    evt_ack = 4'h1;
    tick();
    chk("R7 cleared by ack rise", 32'(evt_req[0]), 0);
    repeat (5) tick();
    chk("R9 no new edge while high", 32'(evt_req[0]), 0);

    // R8 queue while ack held
    src_req = 8'h00;
    repeat (3) tick();
    src_req = 8'h10;
    tick(); tick();
    chk("R8 not yet", 32'(evt_req[0]), 0);
    tick();
    chk("R8 queued while ack high", 32'(evt_req[0]), 1);
    repeat (3) tick();
    chk("R8 held", 32'(evt_req[0]), 1);
    evt_ack = 4'h0; tick();
    evt_ack = 4'h1; tick();
    chk("R7 second clear", 32'(evt_req[0]), 0);
    evt_ack = 4'h0; src_req = 8'h00;
    repeat (4) tick();

    // R2 masked source
    wr(2'd0, 8'hFE);
    src_req = 8'h01;
    repeat (6) tick();
    chk("R2 masked no request", 32'(evt_req), 0);
    rd(2'd1, d); chk("R3 status ignores mask", 32'(d), 32'h01);

    // R5 mapping
    src_req = 8'h00;
    wr(2'd0, 8'hFF);
    repeat (4) tick();
    src_req = 8'h04;
    repeat (3) tick();
    chk("R5 src2 to evt2", 32'(evt_req), 32'h4);
    src_req = 8'h84;
    repeat (3) tick();
    chk("R5 src7 to evt3", 32'(evt_req), 32'hC);
    src_req = 8'h00; evt_ack = 4'hF;
    tick();
    evt_ack = 4'h0;
    chk("R7 all cleared", 32'(evt_req), 0);

    // R4 / R10 wakeup
    wr(2'd2, 8'h08);
    rd(2'd2, d); chk("R4 wake enable readback", 32'(d), 32'h08);
    wr(2'd0, 8'h00);
    core_idle = 1'b1; src_req = 8'h08;
    tick();
    chk("R10 wake with mask zero", 32'(wake_o), 1);
    core_idle = 1'b0;
    tick();
    chk("R10 wake drops when not idle", 32'(wake_o), 0);
    core_idle = 1'b1; src_req = 8'h04;
    tick();
    chk("R10 no wake for disabled source", 32'(wake_o), 0);
    rd(2'd3, d); chk("R11 addr3 again", 32'(d), 0);

    repeat (4) tick();
    done = 1'b1;
    report();
  end
endmodule